// File: doc/BRIEF.md
# Keyed Indexed Configuration Window

This block is a small configuration space that a host reaches through two byte-wide ports selected by a one-bit offset: offset 0 is the index port and offset 1 is the data port. The window starts closed. Writing the opening key (0x55) to the index port opens it, and writing the closing key (0xAA) there closes it again. While the window is open, any other byte written to the index port selects an internal register, and the data port then reads or writes that register.

The internal registers are read-only identity bytes (vendor, product and chip version), a 16-bit base address for a separate data-register block, and an activate bit. The base address and the activate bit leave the block as outputs, so the data-register block can be placed and enabled from them. Reads are registered, so a read strobe returns its byte on `rdata` one clock later, and `rdata` holds that byte until the next read.

Top module: `cfgpair_top`

## Requirements
- R1: After synchronous reset `rdata` is 0x00, `iface_active` is 0, `base_addr` is 0x0000 and the window is closed.
- R2: A write of 0x55 to offset 0 opens the window, and a write of 0xAA to offset 0 closes it. Neither key changes the selected index.
- R3: While the window is closed, a read of either offset returns 0xFF.
- R4: While the window is closed, writes to offset 1 and non-key writes to offset 0 change no register, no index and no output.
- R5: With the window open, index 0xF1/0xF2 reads the vendor ID low/high byte (default 0x15D1), 0xF3/0xF4 reads the product ID low/high byte (default 0x000B), and 0x20/0x21 reads the chip version low/high byte (default 0x0106).
- R6: With the window open, index 0x60 holds the high byte and 0x61 the low byte of `base_addr`. Both bytes are written through offset 1 and read back the value written.
- R7: With the window open, a write to index 0x30 loads bit 0 of the byte into `iface_active`. A read of index 0x30 returns that bit in bit 0, with zeros above it.
- R8: Reads of any index that is not implemented return 0x00.
- R9: Writes to the identity indices and to unimplemented indices have no effect.
- R10: A read strobe updates `rdata` at the next clock edge. Without a read strobe, `rdata` holds its value.
- R11: With the window open, a read of offset 0 returns the currently selected index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| port_sel | input | 1 | Offset: 0 index port, 1 data port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| base_addr | output | 16 | Data-register base address |
| iface_active | output | 1 | Activate flag for the data-register block |

## Verification
Every result of this block arrives at the first clock edge after the strobe that causes it. A read byte appears on `rdata` one edge after `rd_en`, and a write reaches the window state, `base_addr` and `iface_active` one edge after `wr_en`. The bench drives each strobe for exactly one cycle from the falling edge. It samples on the next falling edge, after the register has taken the value and before the inputs change again. Closed-window stimulus is followed by reopening the window and reading the state back, so that any effect of an ignored write would show on the ports.

// File: rtl/cfgpair_pkg.sv
package cfgpair_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] KEY_OPEN  = 8'h55;
    localparam logic [BYTE_W-1:0] KEY_CLOSE = 8'hAA;
    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

    localparam logic [BYTE_W-1:0] IX_VEN_LO  = 8'hF1;
    localparam logic [BYTE_W-1:0] IX_VEN_HI  = 8'hF2;
    localparam logic [BYTE_W-1:0] IX_PRD_LO  = 8'hF3;
    localparam logic [BYTE_W-1:0] IX_PRD_HI  = 8'hF4;
    localparam logic [BYTE_W-1:0] IX_VER_LO  = 8'h20;
    localparam logic [BYTE_W-1:0] IX_VER_HI  = 8'h21;
    localparam logic [BYTE_W-1:0] IX_BASE_HI = 8'h60;
    localparam logic [BYTE_W-1:0] IX_BASE_LO = 8'h61;
    localparam logic [BYTE_W-1:0] IX_ACT     = 8'h30;

    typedef enum logic {
        PORT_INDEX = 1'b0,
        PORT_DATA  = 1'b1
    } port_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } base_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        port_e             port;
        logic [BYTE_W-1:0] data;
    } bus_req_t;

    function automatic logic is_key(input logic [BYTE_W-1:0] b);
        return (b == KEY_OPEN) || (b == KEY_CLOSE);
    endfunction

endpackage

// File: rtl/cfgpair_gate.sv
module cfgpair_gate
    import cfgpair_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              idx_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              open_q,
    output logic [BYTE_W-1:0] index_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q  <= 1'b0;
            index_q <= '0;
        end else if (idx_wr) begin
            if (wdata == KEY_OPEN) begin
                open_q <= 1'b1;
            end else if (wdata == KEY_CLOSE) begin
                open_q <= 1'b0;
            end else if (open_q) begin
                index_q <= wdata;
            end
        end
    end

endmodule

// File: rtl/cfgpair_regs.sv
module cfgpair_regs
    import cfgpair_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VENDOR_ID  = 16'h15D1,
    parameter logic [ADDR_W-1:0] PRODUCT_ID = 16'h000B,
    parameter logic [ADDR_W-1:0] CHIP_VER   = 16'h0106
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dat_wr,
    input  logic [BYTE_W-1:0] index,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rd_byte,
    output base_t             base_q,
    output logic              active_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            active_q <= 1'b0;
        end else if (dat_wr) begin
            unique case (index)
                IX_BASE_HI: base_q.hi <= wdata;
                IX_BASE_LO: base_q.lo <= wdata;
                IX_ACT:     active_q  <= wdata[0];
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (index)
            IX_VEN_LO:  rd_byte = VENDOR_ID[BYTE_W-1:0];
            IX_VEN_HI:  rd_byte = VENDOR_ID[ADDR_W-1:BYTE_W];
            IX_PRD_LO:  rd_byte = PRODUCT_ID[BYTE_W-1:0];
            IX_PRD_HI:  rd_byte = PRODUCT_ID[ADDR_W-1:BYTE_W];
            IX_VER_LO:  rd_byte = CHIP_VER[BYTE_W-1:0];
            IX_VER_HI:  rd_byte = CHIP_VER[ADDR_W-1:BYTE_W];
            IX_BASE_HI: rd_byte = base_q.hi;
            IX_BASE_LO: rd_byte = base_q.lo;
            IX_ACT:     rd_byte = {{(BYTE_W-1){1'b0}}, active_q};
            default:    rd_byte = '0;
        endcase
    end

endmodule

// File: rtl/cfgpair_top.sv
module cfgpair_top
    import cfgpair_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h15D1,
    parameter logic [15:0] PRODUCT_ID = 16'h000B,
    parameter logic [15:0] CHIP_VER   = 16'h0106
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic        port_sel,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic [15:0] base_addr,
    output logic        iface_active
);

    bus_req_t          req;
    logic              pair_open;
    logic [BYTE_W-1:0] cur_index;
    logic [BYTE_W-1:0] reg_byte;
    logic [BYTE_W-1:0] rd_next;
    base_t             base_q;

    assign req = '{wr: wr_en, rd: rd_en, port: port_e'(port_sel), data: wdata};

    cfgpair_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .idx_wr  (req.wr && req.port == PORT_INDEX),
        .wdata   (req.data),
        .open_q  (pair_open),
        .index_q (cur_index)
    );

    cfgpair_regs #(
        .VENDOR_ID  (VENDOR_ID),
        .PRODUCT_ID (PRODUCT_ID),
        .CHIP_VER   (CHIP_VER)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .dat_wr   (req.wr && req.port == PORT_DATA && pair_open),
        .index    (cur_index),
        .wdata    (req.data),
        .rd_byte  (reg_byte),
        .base_q   (base_q),
        .active_q (iface_active)
    );

    assign base_addr = base_q;

    always_comb begin
        if (!pair_open)
            rd_next = IDLE_BYTE;
        else if (req.port == PORT_INDEX)
            rd_next = cur_index;
        else
            rd_next = reg_byte;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (req.rd)
            rdata <= rd_next;
    end

endmodule

// File: rtl/cfgpair_chk.sv
module cfgpair_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        rd_en,
    input logic        port_sel,
    input logic [7:0]  wdata,
    input logic [7:0]  rdata,
    input logic        pair_open,
    input logic [7:0]  cur_index,
    input logic [15:0] base_addr,
    input logic        iface_active
);

    // R2
    open_key_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && !port_sel && wdata == 8'h55 |=> pair_open);

    // R2
    close_key_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && !port_sel && wdata == 8'hAA |=> !pair_open);

    // R3
    closed_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && !pair_open |=> rdata == 8'hFF);

    // R4
    closed_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && port_sel && !pair_open |=> $stable(base_addr) && $stable(iface_active));

    // R6
    base_hi_wr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && port_sel && pair_open && cur_index == 8'h60 |=> base_addr[15:8] == $past(wdata));

    // R7
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && port_sel) |=> $stable(iface_active) && $stable(base_addr));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    // R11
    index_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && !port_sel && pair_open && !wr_en |=> rdata == $past(cur_index));

endmodule

bind cfgpair_top cfgpair_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .port_sel     (port_sel),
    .wdata        (wdata),
    .rdata        (rdata),
    .pair_open    (pair_open),
    .cur_index    (cur_index),
    .base_addr    (base_addr),
    .iface_active (iface_active)
);

// File: tb/cfgpair_top_test.sv
`timescale 1ns/1ps
module cfgpair_top_test;

    localparam logic [15:0] VID = 16'h15D1;
    localparam logic [15:0] PID = 16'h000B;
    localparam logic [15:0] VER = 16'h0106;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        port_sel = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] base_addr;
    logic        iface_active;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m_base = '0;
    logic        m_act = 1'b0;

    always #2 clk = ~clk;

    cfgpair_top uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .port_sel(port_sel), .wdata(wdata), .rdata(rdata),
        .base_addr(base_addr), .iface_active(iface_active)
    );

    function automatic logic [7:0] expect_reg(input logic [7:0] ix);
        case (ix)
            8'hF1: return VID[7:0];
            8'hF2: return VID[15:8];
            8'hF3: return PID[7:0];
            8'hF4: return PID[15:8];
            8'h20: return VER[7:0];
            8'h21: return VER[15:8];
            8'h60: return m_base[15:8];
            8'h61: return m_base[7:0];
            8'h30: return {7'b0, m_act};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; port_sel = sel; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [7:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; port_sel = sel;
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", rdata, 8'h00);
        check("R1 active", iface_active, 1'b0);
        check("R1 base", base_addr, 16'h0000);
        rd(1'b1, 8'hFF, "R1 closed after reset");

        // R3 closed reads on both offsets
        rd(1'b0, 8'hFF, "R3 index closed");
        rd(1'b1, 8'hFF, "R3 data closed");

        // R10 hold without strobe
        repeat (3) @(negedge clk);
        check("R10 hold", rdata, 8'hFF);

        // R2 open, R11 index readback
        wr(1'b0, 8'h55);
        rd(1'b0, 8'h00, "R2 opened / R11 index");
        wr(1'b0, 8'hF1);
        rd(1'b0, 8'hF1, "R11 index F1");
        wr(1'b0, 8'hAA);
        rd(1'b0, 8'hFF, "R2 closed");
        wr(1'b0, 8'h55);
        rd(1'b0, 8'hF1, "R2 keys keep index");

        // R5/R8 sweep of all selectable indices
        for (int i = 0; i < 256; i++) begin
            if (i == 8'h55 || i == 8'hAA) continue;
            wr(1'b0, 8'(i));
            rd(1'b1, expect_reg(8'(i)), "R5/R8 sweep");
        end

        // R6 base write patterns
        for (int p = 0; p < 6; p++) begin
            logic [15:0] v;
            v = 16'h1234 * 16'(p + 1) ^ 16'hA5C3;
            wr(1'b0, 8'h60); wr(1'b1, v[15:8]);
            wr(1'b0, 8'h61); wr(1'b1, v[7:0]);
            m_base = v;
            check("R6 base out", base_addr, v);
            wr(1'b0, 8'h60); rd(1'b1, v[15:8], "R6 hi readback");
            wr(1'b0, 8'h61); rd(1'b1, v[7:0], "R6 lo readback");
        end

        // R7 activate
        wr(1'b0, 8'h30); wr(1'b1, 8'h01);
        m_act = 1'b1;
        check("R7 active set", iface_active, 1'b1);
        rd(1'b1, 8'h01, "R7 readback");
        wr(1'b1, 8'hFE);
        m_act = 1'b0;
        check("R7 bit0 only", iface_active, 1'b0);
        wr(1'b1, 8'h01);
        m_act = 1'b1;

        // R9 writes to read-only and unimplemented indices
        for (int i = 0; i < 256; i++) begin
            if (i == 8'h55 || i == 8'hAA || i == 8'h60 || i == 8'h61 || i == 8'h30) continue;
            wr(1'b0, 8'(i));
            wr(1'b1, 8'h5A);
            rd(1'b1, expect_reg(8'(i)), "R9 no effect");
        end
        check("R9 base kept", base_addr, m_base);
        check("R9 active kept", iface_active, m_act);

        // R4 closed writes ignored
        wr(1'b0, 8'h60);
        wr(1'b0, 8'hAA);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h30);
        wr(1'b1, 8'h00);
        check("R4 base", base_addr, m_base);
        check("R4 active", iface_active, m_act);
        wr(1'b0, 8'h55);
        rd(1'b0, 8'h60, "R4 index kept");
        rd(1'b1, m_base[15:8], "R4 reg kept");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule